// File: doc/BRIEF.md
# Serial EEPROM configuration loader

This block fills a board's setup registers from a 64-word by 16-bit three-wire serial EEPROM and writes them back on request. After hardware reset it reads two setup words and the 48-bit station address without software help. Software can repeat the load at any time, and it can save the configuration and base registers into the EEPROM. A 3-bit jumper input picks which pair of EEPROM words belongs to this board, so identical boards in one system can differ only in their jumpers. The station address always comes from the same three words. One jumper code (7) skips the pair and uses built-in defaults instead. This lets an unprogrammed EEPROM still produce a usable board.

A small control register holds three bits: a general-purpose select bit, a reload bit and a store bit. A read-only busy flag sits beside them. While the select bit is 1 the automatic sequences are bypassed. Reload and store clear themselves when their sequence ends. The serial clock is the system clock divided by a parameter. Chip select stays low for at least one serial-clock period between commands. A store first enables writes, waits for the EEPROM to report ready after each word, and disables writes at the end.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Reset leaves the control bits at reload=1, select=0, store=0 and immediately starts a load, so busy (ctrl_rdata bit 3) reads 1 two cycles after reset is released. When the load ends, ctrl_rdata reads 0.
- R2: For a jumper value j from 0 to 6, a load sets cfg_q to EEPROM word 4*j and base_q to word 4*j+1. The jumper is sampled when a sequence starts.
- R3: Every load sets mac_q[15:0] from word 0x20, mac_q[31:16] from word 0x21 and mac_q[47:32] from word 0x22, whatever the jumper value.
- R4: With jumper value 7, a load sets cfg_q and base_q to the CFG_DEFAULT and BASE_DEFAULT parameters and still loads mac_q from words 0x20 to 0x22.
- R5: Writing ctrl_wdata with bit 1 set (reload) starts a load. The reload bit reads 1 until the load ends and then reads 0.
- R6: Writing ctrl_wdata with bit 2 set (store) writes cfg_q to word 4*j and base_q to word 4*j+1 and changes no other EEPROM word. The store bit then reads 0.
- R7: A store sends a write-enable command (opcode 00, address 11xxxx) before its first write. After each word write it keeps chip select high and waits for ee_do to read 1 before the next command. It ends with a write-disable command (opcode 00, address 00xxxx).
- R8: While the select bit (ctrl_wdata bit 0) is 1, no sequence starts. Chip select stays low, and the reload and store bits read back as written.
- R9: While busy, writes to the control register and to cfg_q and base_q are ignored.
- R10: Each command is sent MSB first as start bit 1, a 2-bit opcode (10 read, 01 write) and a 6-bit address. ee_di changes only while ee_sk is low. The EEPROM takes ee_di on each rising ee_sk. Read data is taken MSB first, after one dummy bit. ee_sk pulses only while ee_cs is high. Chip select stays low for at least 2*CLK_DIV cycles between commands.
- R11: If reload and store are set together, the load runs first and the store follows. The EEPROM words therefore receive the freshly loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| jumper | input | 3 | Board jumper code selecting the setup word pair |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Bit 0 select, bit 1 reload, bit 2 store |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration register write data |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | 16 | Base register write data |
| ctrl_rdata | output | 4 | Bit 0 select, bit 1 reload, bit 2 store, bit 3 busy |
| cfg_q | output | 16 | Configuration register |
| base_q | output | 16 | Base register |
| mac_q | output | 48 | Station address |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready flag from the EEPROM |

## Verification
Suppose the word-step counter or the latched jumper is wrong. Then a wrong EEPROM word lands in cfg_q, base_q or one slice of mac_q. This is visible at the ports as soon as busy falls, about 1100 system cycles after a load starts. Suppose instead the opcode or the poll logic is wrong. Then the EEPROM model shows it within the same store: words are left unwritten or extra words are touched, write-enable is left on, or a command starts while the EEPROM is still busy. A bad shift count or bit order scrambles every loaded word. A stuck sequencer state shows up as busy that never falls.

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int          CLK_DIV      = 4,
  parameter logic [15:0] CFG_DEFAULT  = 16'hA0B1,
  parameter logic [15:0] BASE_DEFAULT = 16'h3C5D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  jumper,
  input  logic        ctrl_wr,
  input  logic [2:0]  ctrl_wdata,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  input  logic        base_wr,
  input  logic [15:0] base_wdata,
  output logic [3:0]  ctrl_rdata,
  output logic [15:0] cfg_q,
  output logic [15:0] base_q,
  output logic [47:0] mac_q,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int DIVW  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int LCW   = $clog2(2 * CLK_DIV + 1) + 1;
  localparam int CMDW  = 9;
  localparam int FRMW  = CMDW + 16;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_SHIFT, S_POLL} state_t;

  state_t           st;
  logic [DIVW-1:0]  div;
  logic [FRMW-1:0]  tx;
  logic [15:0]      rx;
  logic [4:0]       bitn;
  logic [1:0]       gapn;
  logic [2:0]       step, ios_q;
  logic             is_store, need_poll;
  logic             sel, reload, store;

  logic             tick, busy;
  logic [1:0]       op;
  logic [5:0]       addr;
  logic [15:0]      wd;
  logic [4:0]       nb;
  logic             is_wr;
  logic [5:0]       pair;
  logic [2:0]       last_step;
  logic [15:0]      rx_next;

  assign tick       = (div == DIVW'(CLK_DIV - 1));
  assign busy       = (st != S_IDLE);
  assign ctrl_rdata = {busy, store, reload, sel};
  assign ee_di      = (st == S_SHIFT) && tx[FRMW-1];
  assign pair       = {1'b0, ios_q, 2'b00};
  assign last_step  = is_store ? 3'd3 : 3'd4;
  assign rx_next    = {rx[14:0], ee_do};

  always_comb begin
    op    = 2'b10;
    addr  = 6'h00;
    wd    = 16'h0000;
    nb    = 5'(FRMW);
    is_wr = 1'b0;
    if (!is_store) begin
      case (step)
        3'd0:    addr = pair;
        3'd1:    addr = pair | 6'd1;
        default: addr = 6'h1E + {3'b000, step};
      endcase
    end else begin
      case (step)
        3'd0: begin op = 2'b00; addr = 6'h30; nb = 5'(CMDW); end
        3'd1: begin op = 2'b01; addr = pair;         wd = cfg_q;  is_wr = 1'b1; end
        3'd2: begin op = 2'b01; addr = pair | 6'd1;  wd = base_q; is_wr = 1'b1; end
        default: begin op = 2'b00; addr = 6'h00; nb = 5'(CMDW); end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; tx <= '0; rx <= '0; bitn <= '0; gapn <= '0;
      step <= '0; ios_q <= '0; is_store <= 1'b0; need_poll <= 1'b0;
      sel <= 1'b0; reload <= 1'b1; store <= 1'b0;
      cfg_q <= '0; base_q <= '0; mac_q <= '0;
      ee_cs <= 1'b0; ee_sk <= 1'b0;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (!busy && cfg_wr)  cfg_q  <= cfg_wdata;
      if (!busy && base_wr) base_q <= base_wdata;
      case (st)
        S_IDLE: begin
          if (ctrl_wr) begin
            {store, reload, sel} <= ctrl_wdata;
          end else if (!sel && (reload || store)) begin
            is_store  <= !reload;
            ios_q     <= jumper;
            need_poll <= 1'b0;
            gapn      <= '0;
            step      <= (reload && jumper == 3'd7) ? 3'd2 : 3'd0;
            if (reload && jumper == 3'd7) begin
              cfg_q  <= CFG_DEFAULT;
              base_q <= BASE_DEFAULT;
            end
            st <= S_GAP;
          end
        end
        S_GAP: if (tick) begin
          if (gapn == 2'd2) begin
            ee_cs <= 1'b1;
            ee_sk <= 1'b0;
            if (need_poll) begin
              st <= S_POLL;
            end else begin
              tx   <= {1'b1, op, addr, wd};
              bitn <= '0;
              st   <= S_SHIFT;
            end
          end else begin
            gapn <= gapn + 1'b1;
          end
        end
        S_SHIFT: if (tick) begin
          if (!ee_sk) begin
            ee_sk <= 1'b1;
          end else begin
            ee_sk <= 1'b0;
            tx    <= {tx[FRMW-2:0], 1'b0};
            if (bitn >= 5'(CMDW)) rx <= rx_next;
            if (bitn == nb - 5'd1) begin
              ee_cs <= 1'b0;
              gapn  <= '0;
              if (!is_store) begin
                case (step)
                  3'd0:    cfg_q          <= rx_next;
                  3'd1:    base_q         <= rx_next;
                  3'd2:    mac_q[15:0]    <= rx_next;
                  3'd3:    mac_q[31:16]   <= rx_next;
                  default: mac_q[47:32]   <= rx_next;
                endcase
              end
              if (step == last_step) begin
                st <= S_IDLE;
                if (is_store) store <= 1'b0;
                else          reload <= 1'b0;
              end else begin
                step      <= step + 1'b1;
                need_poll <= is_wr;
                st        <= S_GAP;
              end
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        S_POLL: if (tick && ee_do) begin
          ee_cs     <= 1'b0;
          need_poll <= 1'b0;
          gapn      <= '0;
          st        <= S_GAP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [LCW-1:0] lowcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lowcnt <= '0;
    else if (ee_cs)            lowcnt <= '0;
    else if (lowcnt != '1)     lowcnt <= lowcnt + 1'b1;
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R10
  AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R10
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (lowcnt >= LCW'(2 * CLK_DIV))); // R10
  AST_SEL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && sel && !ctrl_wr) |=> (st == S_IDLE)); // R8
  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!reload && !ee_cs)); // R5
  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> $stable(sel)); // R9
endmodule

// File: tb/sim_eeprom_cfg_loader.sv
module sim_eeprom_cfg_loader;
  localparam int          DIV  = 4;
  localparam logic [15:0] DEFC = 16'hA0B1;
  localparam logic [15:0] DEFB = 16'h3C5D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  jumper = 3'd0;
  logic        ctrl_wr = 1'b0, cfg_wr = 1'b0, base_wr = 1'b0;
  logic [2:0]  ctrl_wdata = 3'd0;
  logic [15:0] cfg_wdata = 16'd0, base_wdata = 16'd0;
  logic [3:0]  ctrl_rdata;
  logic [15:0] cfg_q, base_q;
  logic [47:0] mac_q;
  logic        ee_cs, ee_sk, ee_di, ee_do;

  eeprom_cfg_loader #(.CLK_DIV(DIV), .CFG_DEFAULT(DEFC), .BASE_DEFAULT(DEFB)) u0 (
    .clk(clk), .rst_n(rst_n), .jumper(jumper), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .base_wr(base_wr), .base_wdata(base_wdata),
    .ctrl_rdata(ctrl_rdata), .cfg_q(cfg_q), .base_q(base_q), .mac_q(mac_q),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  always #4 clk = ~clk;

  // EEPROM model
  logic [15:0] mem [0:63];
  logic [15:0] snap [0:63];
  logic        poke_en = 1'b0;
  logic [5:0]  poke_a = 6'd0;
  logic [15:0] poke_d = 16'd0;
  logic        sk_d = 1'b0, cs_d = 1'b0, dout = 1'b0, wen = 1'b0;
  int          k = 0, busy_left = 0, viol = 0, bad_start = 0, nwrites = 0;
  int          lowc = 0, minlow = 1000000, rises = 0, nenable = 0;
  logic [8:0]  cmd = 9'd0;
  logic [15:0] sh = 16'd0;

  assign ee_do = ee_cs && ((k > 0) ? dout : (busy_left == 0));

  always @(posedge clk) begin
    logic [8:0]  c;
    logic [15:0] s;
    sk_d <= ee_sk;
    cs_d <= ee_cs;
    if (poke_en) mem[poke_a] <= poke_d;
    if (busy_left > 0) busy_left <= busy_left - 1;
    if (!ee_cs) begin
      k <= 0;
      lowc <= lowc + 1;
    end else begin
      lowc <= 0;
      if (!cs_d) begin
        rises <= rises + 1;
        if (lowc < minlow) minlow <= lowc;
      end
      if (ee_sk && !sk_d) begin
        if (k == 0 && busy_left != 0) viol <= viol + 1;
        k <= k + 1;
        c = (k < 9) ? {cmd[7:0], ee_di} : cmd;
        cmd <= c;
        if (k == 8) begin
          if (!c[8]) bad_start <= bad_start + 1;
          if (c[7:6] == 2'b10) begin sh <= mem[c[5:0]]; dout <= 1'b0; end
          else if (c[7:6] == 2'b00 && c[5:4] == 2'b11) begin wen <= 1'b1; nenable <= nenable + 1; end
          else if (c[7:6] == 2'b00 && c[5:4] == 2'b00) wen <= 1'b0;
        end else if (k >= 9) begin
          if (c[7:6] == 2'b10) begin dout <= sh[15]; sh <= {sh[14:0], 1'b0}; end
          else if (c[7:6] == 2'b01) begin
            s = {sh[14:0], ee_di};
            sh <= s;
            if (k == 24 && wen) begin
              mem[c[5:0]] <= s;
              busy_left <= 300;
              nwrites <= nwrites + 1;
            end
          end
        end
      end
    end
  end

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual=busy expected=idle");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [15:0] exp_cfg(input logic [2:0] j);
    return (j == 3'd7) ? DEFC : mem[{1'b0, j, 2'b00}];
  endfunction
  function automatic logic [15:0] exp_base(input logic [2:0] j);
    return (j == 3'd7) ? DEFB : mem[{1'b0, j, 2'b01}];
  endfunction
  function automatic logic [47:0] exp_mac();
    return {mem[34], mem[33], mem[32]};
  endfunction

  task automatic poke(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 1'b0;
  endtask
  task automatic host_ctrl(input logic [2:0] d);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask
  task automatic host_regs(input logic [15:0] c, input logic [15:0] b);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = c; base_wr = 1'b1; base_wdata = b;
    @(negedge clk); cfg_wr = 1'b0; base_wr = 1'b0;
  endtask
  task automatic wait_idle();
    int q = 0;
    while (q < 6) begin
      @(negedge clk);
      if (ctrl_rdata[3]) q = 0; else q++;
    end
  endtask
  task automatic take_snap();
    for (int i = 0; i < 64; i++) snap[i] = mem[i];
  endtask
  function automatic int count_diff(input logic [5:0] a0);
    int n = 0;
    for (int i = 0; i < 64; i++)
      if (i != a0 && i != a0 + 1 && mem[i] != snap[i]) n++;
    return n;
  endfunction

  initial begin
    logic [2:0]  j;
    logic [15:0] vc, vb;
    int          w0, cs0;
    void'($urandom(32'd7411));
    j = 3'($urandom_range(6, 0));
    jumper = j;
    for (int i = 0; i < 64; i++) poke(6'(i), 16'($urandom));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ctrl_rdata[3] && ctrl_rdata[1], "R1 busy+reload after reset", 64'(ctrl_rdata), 64'hA);
    wait_idle();
    check(ctrl_rdata == 4'd0, "R1 ctrl after reset load", 64'(ctrl_rdata), 64'd0);
    check(cfg_q == exp_cfg(j), "R2 cfg after reset", 64'(cfg_q), 64'(exp_cfg(j)));
    check(base_q == exp_base(j), "R2 base after reset", 64'(base_q), 64'(exp_base(j)));
    check(mac_q == exp_mac(), "R3 mac after reset", 64'(mac_q), 64'(exp_mac()));

    // jumper 7 through reset
    rst_n = 1'b0; jumper = 3'd7;
    poke(6'd28, 16'h1111); poke(6'd29, 16'h2222);
    @(negedge clk); rst_n = 1'b1;
    wait_idle();
    check(cfg_q == DEFC, "R4 cfg default", 64'(cfg_q), 64'(DEFC));
    check(base_q == DEFB, "R4 base default", 64'(base_q), 64'(DEFB));
    check(mac_q == exp_mac(), "R4 mac still loaded", 64'(mac_q), 64'(exp_mac()));

    // reload under several jumpers
    for (int t = 0; t < 5; t++) begin
      j = (t == 4) ? 3'd7 : 3'($urandom_range(7, 0));
      jumper = j;
      for (int i = 0; i < 64; i++) poke(6'(i), 16'($urandom));
      host_ctrl(3'b010);
      @(negedge clk);
      check(ctrl_rdata[3] && ctrl_rdata[1], "R5 reload busy", 64'(ctrl_rdata), 64'hA);
      wait_idle();
      check(ctrl_rdata[1] == 1'b0, "R5 reload cleared", 64'(ctrl_rdata), 64'd0);
      check(cfg_q == exp_cfg(j), "R2 cfg reload", 64'(cfg_q), 64'(exp_cfg(j)));
      check(base_q == exp_base(j), "R2 base reload", 64'(base_q), 64'(exp_base(j)));
      check(mac_q == exp_mac(), "R3 mac reload", 64'(mac_q), 64'(exp_mac()));
    end

    // store, corner jumpers 0 and 6 then random
    for (int t = 0; t < 4; t++) begin
      j = (t == 0) ? 3'd0 : (t == 1) ? 3'd6 : 3'($urandom_range(6, 0));
      jumper = j;
      vc = 16'($urandom); vb = 16'($urandom);
      host_regs(vc, vb);
      take_snap();
      w0 = nwrites;
      cs0 = nenable;
      host_ctrl(3'b100);
      wait_idle();
      check(mem[{1'b0, j, 2'b00}] == vc, "R6 cfg stored", 64'(mem[{1'b0, j, 2'b00}]), 64'(vc));
      check(mem[{1'b0, j, 2'b01}] == vb, "R6 base stored", 64'(mem[{1'b0, j, 2'b01}]), 64'(vb));
      check(count_diff({1'b0, j, 2'b00}) == 0, "R6 other words untouched", 64'(count_diff({1'b0, j, 2'b00})), 64'd0);
      check(ctrl_rdata == 4'd0, "R6 store cleared", 64'(ctrl_rdata), 64'd0);
      check(nwrites - w0 == 2 && nenable - cs0 == 1, "R7 enable then two writes", 64'(nwrites - w0), 64'd2);
      check(wen == 1'b0, "R7 write disabled at end", 64'(wen), 64'd0);
      check(viol == 0, "R7 ready polled before next command", 64'(viol), 64'd0);
    end

    // writes while busy are ignored
    jumper = 3'd2;
    host_regs(16'h5A5A, 16'hC3C3);
    host_ctrl(3'b100);
    repeat (20) @(negedge clk);
    host_regs(16'h0F0F, 16'hF0F0);
    host_ctrl(3'b010);
    wait_idle();
    check(cfg_q == 16'h5A5A && base_q == 16'hC3C3, "R9 reg writes ignored while busy", {32'd0, cfg_q, base_q}, 64'h5A5AC3C3);
    check(ctrl_rdata == 4'd0, "R9 ctrl write ignored while busy", 64'(ctrl_rdata), 64'd0);
    check(mem[8] == 16'h5A5A && mem[9] == 16'hC3C3, "R9 stored values unaffected", {32'd0, mem[8], mem[9]}, 64'h5A5AC3C3);

    // select bypass
    cs0 = rises;
    host_ctrl(3'b011);
    repeat (300) @(negedge clk);
    check(ctrl_rdata == 4'b0011, "R8 select bypass readback", 64'(ctrl_rdata), 64'h3);
    check(rises == cs0, "R8 chip select stays low", 64'(rises), 64'(cs0));
    host_ctrl(3'b101);
    repeat (300) @(negedge clk);
    check(ctrl_rdata == 4'b0101 && rises == cs0, "R8 store bypassed", 64'(ctrl_rdata), 64'h5);
    host_ctrl(3'b000);

    // reload and store together
    j = 3'd3; jumper = j;
    poke(6'd12, 16'hBEEF); poke(6'd13, 16'hCAFE);
    host_regs(16'h1234, 16'h5678);
    take_snap();
    host_ctrl(3'b110);
    wait_idle();
    check(cfg_q == 16'hBEEF && base_q == 16'hCAFE, "R11 load ran first", {32'd0, cfg_q, base_q}, 64'hBEEFCAFE);
    check(mem[12] == 16'hBEEF && mem[13] == 16'hCAFE, "R11 store wrote loaded values", {32'd0, mem[12], mem[13]}, 64'hBEEFCAFE);
    check(ctrl_rdata == 4'd0, "R11 both bits cleared", 64'(ctrl_rdata), 64'd0);

    check(minlow >= 2 * DIV, "R10 chip select low gap", 64'(minlow), 64'(2 * DIV));
    check(bad_start == 0, "R10 start bit present", 64'(bad_start), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule